// File: doc/BRIEF.md
# In-Order Issue Hazard Gate

This block sits at the issue stage of an in-order processor with two integer execution pipes and two floating-point pipes. Every cycle the slotting stage presents a group of up to four instructions. Each slot carries a valid bit, the pipe it is bound for and an instruction class. The gate answers in the same cycle with a per-slot issue enable and a group-complete flag. The slotting stage holds the group until the flag is raised. A slot that issued in an earlier cycle of the same group is remembered and is not issued a second time.

Three hazards hold slots back. The first is advance notice that the cache unit will request a speculative integer register-file fill one or two cycles from now; each distance blocks a different set of classes, and only for the integer pipes. The second is a trap barrier: once one issues, nothing more issues until the machine reports that all earlier instructions are trap-safe. The third is ordering: any blocked slot also blocks every later slot, so issue never runs out of order.

Top module: `issue_gate`

## Requirements
- R1: A slot issues only when its valid bit is set; empty slots are skipped and do not block later slots.
- R2: With `fillIn2` high, a slot bound for an integer pipe (pipe code 0 or 1) with class ALU (code 0) or LOAD (code 3) does not issue.
- R3: With `fillIn2` high and `fillIn1` low, integer-pipe slots of class MUL (1), NORES (2), STORE (4), MEMBAR (5) or TBAR (6) are not held back.
- R4: With `fillIn1` high, an integer-pipe slot of class LOAD (3), STORE (4) or MEMBAR (5) does not issue.
- R5: Slots bound for the floating-point pipes (pipe code 2 or 3) ignore both fill inputs.
- R6: When a TBAR (class 6) slot issues, no later slot of that cycle issues. No slot issues in the following cycles until `trapSafe` has been seen high. Issue resumes on the cycle after that. If a barrier issues in the same cycle that `trapSafe` is high, the barrier wins and the hold stays set.
- R7: If a candidate slot is blocked, every later slot of the group is blocked in that cycle.
- R8: A slot that issued stays issued until the group completes and never issues again within the group. `groupDone` is high when every valid slot has issued, this cycle or earlier. The remembered set is cleared after the group completes.
- R9: After reset, no barrier hold is pending and no slot is marked issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotValid | input | 4 | Slot holds an instruction from the slotting stage |
| slotPipe | input | 8 | Target pipe per slot, 2 bits each, slot 0 lowest (0,1 integer; 2,3 floating) |
| slotClass | input | 12 | Class per slot, 3 bits each, slot 0 lowest |
| fillIn2 | input | 1 | Integer register fill will be requested two cycles from now |
| fillIn1 | input | 1 | Integer register fill will be requested one cycle from now |
| trapSafe | input | 1 | All previously issued instructions are trap-safe |
| issueEn | output | 4 | Per-slot issue enable for this cycle |
| groupDone | output | 1 | Every valid slot of the group has issued; next group may be presented |

## Verification
The bench targets groups where a blocked slot sits ahead of slots that would otherwise issue. A gate without the ordering chain would issue those later slots out of order. Groups that finish over several cycles show whether earlier issued slots are fired twice or whether `groupDone` rises too early. Barrier groups with `trapSafe` arriving one cycle late show whether issue resumes a cycle early or not at all. Mixed-class groups under each fill distance show whether the exemptions for multiplies, result-less instructions and floating-point pipes are handled correctly.

// File: rtl/issue_gate_pkg.sv
package issue_gate_pkg;

  localparam int unsigned PIPE_W = 2;
  localparam int unsigned CLS_W  = 3;

  typedef enum logic [PIPE_W-1:0] {
    PIPE_INT0 = 2'd0,
    PIPE_INT1 = 2'd1,
    PIPE_FADD = 2'd2,
    PIPE_FMUL = 2'd3
  } pipe_e;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU    = 3'd0,
    CLS_MUL    = 3'd1,
    CLS_NORES  = 3'd2,
    CLS_LOAD   = 3'd3,
    CLS_STORE  = 3'd4,
    CLS_MEMBAR = 3'd5,
    CLS_TBAR   = 3'd6
  } cls_e;

  // control -> slot logic
  typedef struct packed {
    logic barrierHold;
  } gateStrobe_t;

  // slot logic -> control
  typedef struct packed {
    logic barrierIssued;
    logic groupDone;
  } gateStatus_t;

endpackage

// File: rtl/issue_gate_slots.sv
module issue_gate_slots
  import issue_gate_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic [SLOTS-1:0]        slotValid,
  input  logic [SLOTS*PIPE_W-1:0] slotPipe,
  input  logic [SLOTS*CLS_W-1:0]  slotClass,
  input  logic                    fillIn2,
  input  logic                    fillIn1,
  input  gateStrobe_t             strobe,
  input  logic [SLOTS-1:0]        issuedMask,
  output logic [SLOTS-1:0]        issueEn,
  output gateStatus_t             status
);

  logic [SLOTS:0]   chainOk;
  logic [SLOTS-1:0] complete;
  logic [SLOTS-1:0] barIssue;

  assign chainOk[0] = 1'b1;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    pipe_e pipe;
    cls_e  cls;
    logic  isInt, cand, near2, near1, hazard, isBar;

    assign pipe  = pipe_e'(slotPipe[i*PIPE_W +: PIPE_W]);
    assign cls   = cls_e'(slotClass[i*CLS_W +: CLS_W]);
    assign isInt = (pipe == PIPE_INT0) || (pipe == PIPE_INT1);
    assign isBar = (cls == CLS_TBAR);
    assign cand  = slotValid[i] & ~issuedMask[i];

    // two-cycle look-ahead: result-producing, non-multiply integer work
    assign near2 = fillIn2 & isInt & ((cls == CLS_ALU) || (cls == CLS_LOAD));
    // one-cycle look-ahead: memory-class integer work
    assign near1 = fillIn1 & isInt &
                   ((cls == CLS_LOAD) || (cls == CLS_STORE) || (cls == CLS_MEMBAR));

    assign hazard     = near2 | near1 | strobe.barrierHold;
    assign issueEn[i] = cand & ~hazard & chainOk[i];
    assign chainOk[i+1] = chainOk[i] & (~cand | (issueEn[i] & ~isBar));
    assign complete[i]  = ~slotValid[i] | issuedMask[i] | issueEn[i];
    assign barIssue[i]  = issueEn[i] & isBar;
  end

  assign status.groupDone     = &complete;
  assign status.barrierIssued = |barIssue;

endmodule

// File: rtl/issue_gate_ctrl.sv
module issue_gate_ctrl
  import issue_gate_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapSafe,
  input  logic [SLOTS-1:0] issueEn,
  input  gateStatus_t      status,
  output gateStrobe_t      strobe,
  output logic [SLOTS-1:0] issuedMask
);

  logic barPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      barPend    <= 1'b0;
      issuedMask <= '0;
    end else begin
      if (status.barrierIssued) barPend <= 1'b1;
      else if (trapSafe)        barPend <= 1'b0;

      if (status.groupDone) issuedMask <= '0;
      else                  issuedMask <= issuedMask | issueEn;
    end
  end

  assign strobe.barrierHold = barPend;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $rose(rstN) |-> (issuedMask == '0 && !barPend)); // R9

  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (barPend && trapSafe && !status.barrierIssued) |=> !barPend); // R6

endmodule

// File: rtl/issue_gate.sv
module issue_gate
  import issue_gate_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [SLOTS-1:0]        slotValid,
  input  logic [SLOTS*PIPE_W-1:0] slotPipe,
  input  logic [SLOTS*CLS_W-1:0]  slotClass,
  input  logic                    fillIn2,
  input  logic                    fillIn1,
  input  logic                    trapSafe,
  output logic [SLOTS-1:0]        issueEn,
  output logic                    groupDone
);

  gateStrobe_t      strobe;
  gateStatus_t      status;
  logic [SLOTS-1:0] issuedMask;

  issue_gate_slots #(.SLOTS(SLOTS)) u_slots (
    .slotValid (slotValid),
    .slotPipe  (slotPipe),
    .slotClass (slotClass),
    .fillIn2   (fillIn2),
    .fillIn1   (fillIn1),
    .strobe    (strobe),
    .issuedMask(issuedMask),
    .issueEn   (issueEn),
    .status    (status)
  );

  issue_gate_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trapSafe  (trapSafe),
    .issueEn   (issueEn),
    .status    (status),
    .strobe    (strobe),
    .issuedMask(issuedMask)
  );

  assign groupDone = status.groupDone;

  // independent views of the rules for checking
  logic [SLOTS-1:0] viol2, viol1, violOrder;
  always_comb begin
    logic seenBlocked;
    seenBlocked = 1'b0;
    viol2 = '0;
    viol1 = '0;
    violOrder = '0;
    for (int i = 0; i < SLOTS; i++) begin
      logic [PIPE_W-1:0] p;
      logic [CLS_W-1:0]  c;
      p = slotPipe[i*PIPE_W +: PIPE_W];
      c = slotClass[i*CLS_W +: CLS_W];
      if (issueEn[i] && fillIn2 && p < 2'd2 && (c == 3'd0 || c == 3'd3)) viol2[i] = 1'b1;
      if (issueEn[i] && fillIn1 && p < 2'd2 && c >= 3'd3 && c <= 3'd5)   viol1[i] = 1'b1;
      if (issueEn[i] && seenBlocked) violOrder[i] = 1'b1;
      if (slotValid[i] && !issuedMask[i] && !issueEn[i]) seenBlocked = 1'b1;
    end
  end

  AST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (issueEn & ~slotValid) == '0); // R1

  AST_FILL_TWO: assert property (@(posedge clk) disable iff (!rstN)
    viol2 == '0); // R2

  AST_FILL_ONE: assert property (@(posedge clk) disable iff (!rstN)
    viol1 == '0); // R4

  AST_BARRIER_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    status.barrierIssued |=> (issueEn == '0)); // R6

  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    violOrder == '0); // R7

  for (genvar i = 0; i < SLOTS; i++) begin : g_chk
    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rstN)
      (issueEn[i] && !groupDone) |=> !issueEn[i]); // R8
  end

endmodule

// File: tb/issue_gate_tb.sv
module issue_gate_tb;

  localparam int SLOTS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  slotValid = '0;
  logic [7:0]  slotPipe = '0;
  logic [11:0] slotClass = '0;
  logic        fillIn2 = 1'b0, fillIn1 = 1'b0, trapSafe = 1'b0;
  logic [3:0]  issueEn;
  logic        groupDone;

  int vectors = 0;
  int fails   = 0;

  // reference model state
  logic [3:0] mIssued;
  bit         mPend;
  logic [3:0] expEn;
  bit         expDone;
  bit         expBar;

  always #4 clk = ~clk;

  issue_gate #(.SLOTS(SLOTS)) u_dut (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .slotPipe(slotPipe),
    .slotClass(slotClass), .fillIn2(fillIn2), .fillIn1(fillIn1),
    .trapSafe(trapSafe), .issueEn(issueEn), .groupDone(groupDone)
  );

  task automatic modelEval();
    bit stop;
    stop = 0;
    expEn = '0;
    expBar = 0;
    for (int i = 0; i < SLOTS; i++) begin
      int p, c;
      bit blk;
      p = int'(slotPipe[i*2 +: 2]);
      c = int'(slotClass[i*3 +: 3]);
      if (!slotValid[i] || mIssued[i]) continue;
      blk = mPend || stop;
      if (p <= 1) begin
        if (fillIn2 && (c == 0 || c == 3)) blk = 1;
        if (fillIn1 && (c == 3 || c == 4 || c == 5)) blk = 1;
      end
      if (blk) stop = 1;
      else begin
        expEn[i] = 1'b1;
        if (c == 6) begin stop = 1; expBar = 1; end
      end
    end
    expDone = 1;
    for (int i = 0; i < SLOTS; i++)
      if (slotValid[i] && !mIssued[i] && !expEn[i]) expDone = 0;
  endtask

  task automatic step(input string tag, input logic [3:0] v, input logic [7:0] p,
                      input logic [11:0] c, input logic f2, input logic f1,
                      input logic ts);
    @(negedge clk);
    slotValid = v; slotPipe = p; slotClass = c;
    fillIn2 = f2; fillIn1 = f1; trapSafe = ts;
    #1;
    modelEval();
    vectors++;
    if (issueEn !== expEn || groupDone !== expDone) begin
      fails++;
      $display("FAIL %s: issueEn=%b groupDone=%b expected issueEn=%b groupDone=%b",
               tag, issueEn, groupDone, expEn, expDone);
    end
    @(posedge clk);
    if (expDone) mIssued = '0; else mIssued = mIssued | expEn;
    if (expBar) mPend = 1; else if (ts) mPend = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [3:0]  gv;
    logic [7:0]  gp;
    logic [11:0] gc;
    bit          lastDone;

    mIssued = '0; mPend = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (issueEn !== 4'b0000 || groupDone !== 1'b1) begin
      fails++;
      $display("FAIL R9 in reset: issueEn=%b groupDone=%b expected 0000/1", issueEn, groupDone);
    end
    rstN = 1'b1;

    // R9: clean state, full group on all four pipes issues at once
    step("R9", 4'b1111, {2'd3,2'd2,2'd1,2'd0}, {3'd0,3'd0,3'd0,3'd0}, 0, 0, 0);
    // R1: holes skipped
    step("R1", 4'b0101, {2'd0,2'd1,2'd0,2'd1}, {3'd0,3'd3,3'd0,3'd0}, 0, 0, 0);
    // R2 + R7: slot0 ALU on int pipe blocked, later slots held
    step("R2", 4'b1111, {2'd2,2'd0,2'd1,2'd0}, {3'd0,3'd0,3'd3,3'd0}, 1, 0, 0);
    step("R8", 4'b1111, {2'd2,2'd0,2'd1,2'd0}, {3'd0,3'd0,3'd3,3'd0}, 0, 0, 0);
    // R3: exempt classes under two-cycle look-ahead
    step("R3", 4'b1111, {2'd1,2'd0,2'd1,2'd0}, {3'd2,3'd5,3'd4,3'd1}, 1, 0, 0);
    // R4 + R7: LOAD on E1 blocked, later FP slots held behind it
    step("R4", 4'b1111, {2'd3,2'd2,2'd1,2'd0}, {3'd0,3'd0,3'd3,3'd0}, 0, 1, 0);
    step("R8", 4'b1111, {2'd3,2'd2,2'd1,2'd0}, {3'd0,3'd0,3'd3,3'd0}, 0, 0, 0);
    // R5: floating pipes ignore both fill distances
    step("R5", 4'b1111, {2'd3,2'd2,2'd3,2'd2}, {3'd3,3'd0,3'd4,3'd3}, 1, 1, 0);
    // R6: barrier sequence
    step("R6", 4'b1111, {2'd3,2'd2,2'd1,2'd0}, {3'd0,3'd0,3'd6,3'd0}, 0, 0, 0);
    step("R6", 4'b1111, {2'd3,2'd2,2'd1,2'd0}, {3'd0,3'd0,3'd6,3'd0}, 0, 0, 0);
    step("R6", 4'b1111, {2'd3,2'd2,2'd1,2'd0}, {3'd0,3'd0,3'd6,3'd0}, 0, 0, 1);
    step("R6", 4'b1111, {2'd3,2'd2,2'd1,2'd0}, {3'd0,3'd0,3'd6,3'd0}, 0, 0, 0);
    // R6: barrier issuing with trapSafe high keeps the hold
    step("R6", 4'b0011, {2'd0,2'd0,2'd1,2'd0}, {3'd0,3'd0,3'd0,3'd6}, 0, 0, 1);
    step("R6", 4'b0011, {2'd0,2'd0,2'd1,2'd0}, {3'd0,3'd0,3'd0,3'd6}, 0, 0, 1);
    step("R6", 4'b0011, {2'd0,2'd0,2'd1,2'd0}, {3'd0,3'd0,3'd0,3'd6}, 0, 0, 0);
    // R8: multi-cycle group, no reissue
    step("R8", 4'b1111, {2'd1,2'd0,2'd1,2'd0}, {3'd0,3'd0,3'd3,3'd0}, 0, 1, 0);
    step("R8", 4'b1111, {2'd1,2'd0,2'd1,2'd0}, {3'd0,3'd0,3'd3,3'd0}, 1, 0, 0);
    step("R8", 4'b1111, {2'd1,2'd0,2'd1,2'd0}, {3'd0,3'd0,3'd3,3'd0}, 0, 0, 0);
    // R7: blocked mid-group store under one-cycle look-ahead
    step("R7", 4'b1111, {2'd2,2'd3,2'd0,2'd1}, {3'd0,3'd0,3'd4,3'd1}, 0, 1, 0);
    step("R7", 4'b1111, {2'd2,2'd3,2'd0,2'd1}, {3'd0,3'd0,3'd4,3'd1}, 0, 0, 0);

    // random groups under the hold-until-done protocol
    lastDone = 1;
    gv = '0; gp = '0; gc = '0;
    for (int n = 0; n < 3000; n++) begin
      if (lastDone) begin
        gv = 4'($urandom);
        gp = 8'($urandom);
        for (int i = 0; i < SLOTS; i++) gc[i*3 +: 3] = 3'($urandom % 7);
      end
      step("R7", gv, gp, gc, ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 3) == 0);
      lastDone = expDone;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule